// File: doc/BRIEF.md
# Windowed Modular Exponentiator

This block raises a 12-bit base to a 12-bit power and reduces the result by an odd 12-bit modulus, giving Z = X^Y mod M. It uses a fixed-window (M-ary) schedule. The exponent is split into four 3-bit windows. Before any squaring starts, the block computes the base powers that a window can select and keeps them in a small register bank. It then walks the windows from the most significant one down. For each window it squares the accumulator three times and then, when the window is non-zero, multiplies by the power that the window selects.

Every product is formed by a bit-serial Montgomery multiplier, which sits beside the controller and is reached through a go/done handshake. The caller supplies the constant R^2 mod M, with R = 2^12. The block uses it to move the base and the value one into the Montgomery domain. A final multiply by one brings the result back to ordinary form. A one-cycle start pulse launches a computation, and the done flag reports that the result is ready.

Top module: `mexp_top`

## Requirements
- R1: With M odd, 1 < M < 4096, X < M and rsq_i = (4096*4096) mod M, result_o equals X^Y mod M once done_o is high.
- R2: X=1697, Y=25, M=2773, rsq_i=566 gives 1197, and X=2000, Y=140, M=2901, rsq_i=733 gives 982.
- R3: The exponent is read as four 3-bit fields, bits [11:9] first and bits [2:0] last, and Y=0 yields 1.
- R4: A window of value 0 adds no multiply, and a window of value 1 multiplies by the base itself. Exponents made only of such windows (for example 0x249 and 0x200) still give X^Y mod M.
- R5: Powers X^2 to X^7 are stored at bank addresses 0 to 5 (window value minus 2). Exponents that use every window value from 2 to 7 give correct results.
- R6: done_o falls in the cycle after an accepted start and rises together with the new result_o. It then stays high, with result_o unchanged, until the next start.
- R7: A start pulse that arrives while a computation runs is ignored. The result belongs to the operands captured by the first start.
- R8: After a synchronous active-low reset, done_o is 0 and result_o is 0.
- R9: A base of 0 with a non-zero exponent gives 0, and a base of 1 gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that captures the operands and begins a run |
| base_i | input | 12 | Base X, less than the modulus |
| expo_i | input | 12 | Exponent Y |
| mod_i | input | 12 | Odd modulus M |
| rsq_i | input | 12 | Correction constant R^2 mod M, R = 2^12 |
| result_o | output | 12 | Result X^Y mod M |
| done_o | output | 1 | High when result_o holds a finished result |

## Verification
The bench tries the two published data sets first, because they fix the absolute values of the whole domain-conversion path. Exponents with all windows at 0 or 1 show the skip and direct-base paths apart from the bank path. Exponents that cover every window value from 2 to 7 expose an address offset or a wrong stored power. Exponent 0, bases 0 and 1, the tiny modulus 3 and all-ones operands cover the boundaries of the arithmetic. A second start during a run, and the idle hold after done, check the control sequence.

// File: rtl/mexp_pkg.sv
// Package: shared sizes and state/operation encodings for the windowed
// modular exponentiator. Assumes operands fit in OPW bits.
package mexp_pkg;
    localparam int OPW        = 12;
    localparam int WINB       = 3;
    localparam int NWIN       = 4;
    localparam int BANK_DEPTH = 16;

    typedef enum logic [2:0] {
        ST_IDLE, ST_TOX, ST_ONE, ST_PRE, ST_SQ, ST_MUL, ST_FIX, ST_WAIT
    } st_t;

    typedef enum logic [2:0] {
        OP_TOX, OP_ONE, OP_PRE, OP_SQ, OP_MUL, OP_FIX
    } op_t;
endpackage

// File: rtl/mont_mul.sv
// Bit-serial Montgomery multiplier: p = a*b*2^-W mod m.
// Assumes m odd, b < m. A go pulse captures operands when idle; done
// pulses for one cycle W+1 cycles later with p valid from then on.
module mont_mul #(
    parameter int W = mexp_pkg::OPW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] m,
    output logic         done,
    output logic [W-1:0] p
);
    localparam int CW = $clog2(W + 1);

    logic [W+1:0]  s;
    logic [W-1:0]  a_q, b_q, m_q;
    logic [CW-1:0] cnt;
    logic          busy;
    logic [W+1:0]  t1, t2, s_nx, fin;

    // One radix-2 reduction step and the final conditional subtract.
    always_comb begin
        t1   = s + (a_q[0] ? {2'b00, b_q} : '0);
        t2   = t1[0] ? t1 + {2'b00, m_q} : t1;
        s_nx = t2 >> 1;
        fin  = (s >= {2'b00, m_q}) ? s - {2'b00, m_q} : s;
    end

    // Iteration register: load on go, step W times, then deliver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s    <= '0;
            a_q  <= '0;
            b_q  <= '0;
            m_q  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
            p    <= '0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                a_q  <= a;
                b_q  <= b;
                m_q  <= m;
                s    <= '0;
                cnt  <= '0;
                busy <= 1'b1;
            end else if (busy) begin
                if (cnt == CW'(W)) begin
                    p    <= fin[W-1:0];
                    done <= 1'b1;
                    busy <= 1'b0;
                end else begin
                    s   <= s_nx;
                    a_q <= a_q >> 1;
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pow_bank.sv
// Register bank for precomputed powers: DEPTH words of W bits with a
// write decoder and a read multiplexer sharing one address (one access
// at a time). Cleared by reset.
module pow_bank #(
    parameter int W     = mexp_pkg::OPW,
    parameter int DEPTH = mexp_pkg::BANK_DEPTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] regs [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // Word g: written only when the decoder selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && addr == AW'(g))
                regs[g] <= wdata;
        end
    end

    // Read multiplexer.
    assign rdata = regs[addr];
endmodule

// File: rtl/win_sel.sv
// Exponent window selector: returns field idx of width WINB from y.
module win_sel #(
    parameter int WINB = mexp_pkg::WINB,
    parameter int NWIN = mexp_pkg::NWIN,
    localparam int IW  = $clog2(NWIN)
) (
    input  logic [WINB*NWIN-1:0] y,
    input  logic [IW-1:0]        idx,
    output logic [WINB-1:0]      val
);
    logic [WINB-1:0] fld [NWIN];

    for (genvar g = 0; g < NWIN; g++) begin : g_fld
        assign fld[g] = y[g*WINB +: WINB];
    end

    assign val = fld[idx];
endmodule

// File: rtl/mexp_top.sv
// Fixed-window modular exponentiator: result = base^expo mod mod_i.
// Assumes mod_i odd and > 1, base_i < mod_i, rsq_i = 2^(2*OPW) mod mod_i.
// Moore controller; every product goes through mont_mul.
module mexp_top
    import mexp_pkg::*;
#(
    parameter int OPW        = mexp_pkg::OPW,
    parameter int WINB       = mexp_pkg::WINB,
    parameter int NWIN       = mexp_pkg::NWIN,
    parameter int BANK_DEPTH = mexp_pkg::BANK_DEPTH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [OPW-1:0] base_i,
    input  logic [OPW-1:0] expo_i,
    input  logic [OPW-1:0] mod_i,
    input  logic [OPW-1:0] rsq_i,
    output logic [OPW-1:0] result_o,
    output logic           done_o
);
    localparam int IW   = $clog2(NWIN);
    localparam int AW   = $clog2(BANK_DEPTH);
    localparam int MAXV = (1 << WINB) - 1;
    localparam int SQW  = $clog2(WINB + 1);

    st_t            st;
    op_t            op_q;
    logic [OPW-1:0] x_q, y_q, m_q, r2_q, xm, acc, prev;
    logic [WINB-1:0] pk, val;
    logic [IW-1:0]  win;
    logic [SQW-1:0] sqc;
    logic [OPW-1:0] mul_a, mul_b, mul_p, bank_rd;
    logic           mul_go, mul_done, bank_we;
    logic [AW-1:0]  bank_addr;

    win_sel #(.WINB(WINB), .NWIN(NWIN)) u_win (
        .y(y_q), .idx(win), .val(val)
    );

    pow_bank #(.W(OPW), .DEPTH(BANK_DEPTH)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(bank_we), .addr(bank_addr),
        .wdata(mul_p), .rdata(bank_rd)
    );

    mont_mul #(.W(OPW)) u_mul (
        .clk(clk), .rst_n(rst_n), .go(mul_go), .a(mul_a), .b(mul_b),
        .m(m_q), .done(mul_done), .p(mul_p)
    );

    // Operand selection and multiplier launch, decoded from state only.
    always_comb begin
        mul_go = 1'b1;
        mul_a  = acc;
        mul_b  = acc;
        unique case (st)
            ST_TOX: begin mul_a = x_q;        mul_b = r2_q; end
            ST_ONE: begin mul_a = OPW'(1);    mul_b = r2_q; end
            ST_PRE: begin mul_a = xm;         mul_b = prev; end
            ST_SQ:  begin mul_a = acc;        mul_b = acc;  end
            ST_MUL: begin mul_a = acc;        mul_b = (val == WINB'(1)) ? xm : bank_rd; end
            ST_FIX: begin mul_a = acc;        mul_b = OPW'(1); end
            default: mul_go = 1'b0;
        endcase
    end

    // Bank port: read the selected power in ST_MUL, else point at the write slot.
    assign bank_addr = (st == ST_MUL) ? AW'(val - WINB'(2)) : AW'(pk - WINB'(2));
    assign bank_we   = (st == ST_WAIT) && (op_q == OP_PRE) && mul_done;

    // Controller: sequencing, operand capture and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            op_q     <= OP_TOX;
            x_q      <= '0;
            y_q      <= '0;
            m_q      <= '0;
            r2_q     <= '0;
            xm       <= '0;
            acc      <= '0;
            prev     <= '0;
            pk       <= '0;
            win      <= '0;
            sqc      <= '0;
            result_o <= '0;
            done_o   <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    x_q    <= base_i;
                    y_q    <= expo_i;
                    m_q    <= mod_i;
                    r2_q   <= rsq_i;
                    done_o <= 1'b0;
                    st     <= ST_TOX;
                end
                ST_TOX: begin op_q <= OP_TOX; st <= ST_WAIT; end
                ST_ONE: begin op_q <= OP_ONE; st <= ST_WAIT; end
                ST_PRE: begin op_q <= OP_PRE; st <= ST_WAIT; end
                ST_SQ:  begin op_q <= OP_SQ;  st <= ST_WAIT; end
                ST_MUL: begin op_q <= OP_MUL; st <= ST_WAIT; end
                ST_FIX: begin op_q <= OP_FIX; st <= ST_WAIT; end
                default: if (mul_done) begin
                    unique case (op_q)
                        OP_TOX: begin xm <= mul_p; st <= ST_ONE; end
                        OP_ONE: begin
                            acc  <= mul_p;
                            prev <= xm;
                            pk   <= WINB'(2);
                            st   <= ST_PRE;
                        end
                        OP_PRE: begin
                            prev <= mul_p;
                            if (pk == WINB'(MAXV)) begin
                                win <= IW'(NWIN - 1);
                                sqc <= '0;
                                st  <= ST_SQ;
                            end else begin
                                pk <= pk + 1'b1;
                                st <= ST_PRE;
                            end
                        end
                        OP_SQ: begin
                            acc <= mul_p;
                            if (sqc == SQW'(WINB - 1)) begin
                                sqc <= '0;
                                if (val != '0)
                                    st <= ST_MUL;
                                else if (win == '0)
                                    st <= ST_FIX;
                                else begin
                                    win <= win - 1'b1;
                                    st  <= ST_SQ;
                                end
                            end else begin
                                sqc <= sqc + 1'b1;
                                st  <= ST_SQ;
                            end
                        end
                        OP_MUL: begin
                            acc <= mul_p;
                            if (win == '0)
                                st <= ST_FIX;
                            else begin
                                win <= win - 1'b1;
                                st  <= ST_SQ;
                            end
                        end
                        default: begin
                            result_o <= mul_p;
                            done_o   <= 1'b1;
                            st       <= ST_IDLE;
                        end
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/mexp_chk.sv
// Checker for mexp_top: protocol and range properties, attached by bind.
module mexp_chk #(
    parameter int OPW  = mexp_pkg::OPW,
    parameter int WINB = mexp_pkg::WINB,
    parameter int AW   = $clog2(mexp_pkg::BANK_DEPTH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           done_o,
    input logic [OPW-1:0] result_o,
    input logic [OPW-1:0] m_q,
    input logic           bank_we,
    input logic [AW-1:0]  bank_addr,
    input logic           idle
);
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start |=> done_o);                                  // R6
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && start |=> !done_o);                                  // R6
    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(done_o) |-> $stable(result_o));                         // R6
    AST_RESULT_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> result_o < m_q);                             // R1
    AST_BANK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |-> bank_addr < AW'((1 << WINB) - 2));                 // R5
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        start && !idle |=> $stable(m_q));                              // R7
endmodule

bind mexp_top mexp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done_o(done_o),
    .result_o(result_o), .m_q(m_q), .bank_we(bank_we),
    .bank_addr(bank_addr), .idle(st == mexp_pkg::ST_IDLE)
);

// File: tb/tb_mexp_top.sv
module tb_mexp_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    // Columns: base, exponent, modulus (expected value computed by model).
    localparam logic [35:0] VEC [NVEC] = '{
        {12'd1697, 12'd25,    12'd2773},  // R1 R2
        {12'd2000, 12'd140,   12'd2901},  // R1 R2
        {12'd5,    12'd0,     12'd2773},  // R3
        {12'd123,  12'h249,   12'd4093},  // R4 windows 1,1,1,1
        {12'd77,   12'h200,   12'd3001},  // R4 windows 1,0,0,0
        {12'd999,  12'hFAC,   12'd4095},  // R5 windows 7,6,5,4
        {12'd4094, 12'h0D1,   12'd4095},  // R5 windows 0,3,2,1
        {12'd0,    12'd77,    12'd3},     // R9
        {12'd1,    12'd4095,  12'd4095},  // R9
        {12'd2,    12'd4095,  12'd4093},  // R1
        {12'd3000, 12'hFFF,   12'd4095},  // R1
        {12'd2,    12'd5,     12'd3}      // R1 small modulus
    };

    logic        clk = 0, rst_n = 0, start = 0;
    logic [11:0] base_i = 0, expo_i = 0, mod_i = 0, rsq_i = 0;
    logic [11:0] result_o;
    logic        done_o;
    int          checks = 0, errors = 0;
    bit          finished = 0;

    mexp_top dut (.clk(clk), .rst_n(rst_n), .start(start), .base_i(base_i),
        .expo_i(expo_i), .mod_i(mod_i), .rsq_i(rsq_i),
        .result_o(result_o), .done_o(done_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [11:0] ref_pow(input logic [11:0] x, y, m);
        longint r = 1 % m, b = x % m;
        for (int i = 0; i < 12; i++) begin
            if (y[i]) r = (r * b) % m;
            b = (b * b) % m;
        end
        return 12'(r);
    endfunction

    function automatic logic [11:0] ref_rsq(input logic [11:0] m);
        return 12'((longint'(4096) * 4096) % m);
    endfunction

    task automatic check(input string req, input logic [11:0] act, exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic launch(input logic [11:0] x, y, m, r2);
        @(negedge clk);
        base_i = x; expo_i = y; mod_i = m; rsq_i = r2; start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done_o && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (!done_o) begin
            checks++; errors++;
            $display("FAIL %s: actual=no done expected=done within 3000 cycles", req);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [11:0] first;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 done", 12'(done_o), 12'd0);
        check("R8 result", result_o, 12'd0);
        rst_n = 1;
        @(negedge clk);

        // R1 R3 R4 R5 R9: table walk against the bench model
        for (int i = 0; i < NVEC; i++) begin
            logic [11:0] x = VEC[i][35:24], y = VEC[i][23:12], m = VEC[i][11:0];
            launch(x, y, m, ref_rsq(m));
            check("R6 done falls", 12'(done_o), 12'd0);
            wait_done("R1");
            check("R1 R3 R4 R5 R9 result", result_o, ref_pow(x, y, m));
        end

        // R2: published values with published constants
        launch(12'd1697, 12'd25, 12'd2773, 12'd566);
        wait_done("R2");
        check("R2 set one", result_o, 12'd1197);
        launch(12'd2000, 12'd140, 12'd2901, 12'd733);
        wait_done("R2");
        check("R2 set two", result_o, 12'd982);

        // R6: done and result hold while idle
        first = result_o;
        repeat (20) @(negedge clk);
        check("R6 done held", 12'(done_o), 12'd1);
        check("R6 result held", result_o, first);

        // R7: a second start during a run is ignored
        launch(12'd999, 12'hFAC, 12'd4095, ref_rsq(12'd4095));
        repeat (30) @(negedge clk);
        launch(12'd3, 12'd7, 12'd11, ref_rsq(12'd11));
        check("R7 still busy", 12'(done_o), 12'd0);
        wait_done("R7");
        check("R7 first operands", result_o, ref_pow(12'd999, 12'hFAC, 12'd4095));
        repeat (5) @(negedge clk);
        check("R7 no restart", 12'(done_o), 12'd1);

        // R8: reset mid-run clears outputs
        launch(12'd7, 12'd9, 12'd13, ref_rsq(12'd13));
        repeat (10) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        check("R8 mid-run done", 12'(done_o), 12'd0);
        check("R8 mid-run result", result_o, 12'd0);
        rst_n = 1;

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule